// File: doc/BRIEF.md
# Alarm Match Unit

This block watches a calendar time given as BCD minute, hour, date and weekday fields and raises an alarm when the time reaches a programmed point. Four alarm registers hold the programmed values. Each register carries its own active-low enable in bit 7. A cleared bit 7 means the field takes part in the comparison. A set bit 7 means the field is a don't-care.

The comparison is evaluated only in the cycle in which the time-update strobe is high. A sticky flag records the first matching update that follows a non-matching one. Software clears the flag by writing 0 to its bit in the control register; writing 1 to that bit leaves it alone. While the flag and the interrupt enable are both set, the block asserts a drive-low enable for an open-drain interrupt pin. A simple register write port and a registered read port give access to the alarm registers and the control bits. The time counter and the serial bus interface are outside this block.

Top module: `alarm_match_unit`

## Requirements
- R1: Register addresses are: 0 for control, 1 for the minute alarm, 2 for the hour alarm, 3 for the date alarm and 4 for the weekday alarm. Alarm registers store all 8 written bits and read back unchanged. Control reads as flag in bit 3, interrupt enable in bit 1 and 0 in every other bit. Addresses 5 to 7 read 0 and ignore writes. `rd_data` shows the register at `rd_addr` one clock after the address is applied.
- R2: A field is compared only when bit 7 of its alarm register is 0. The compared bits are [6:0] for the minute, [5:0] for the hour and the date, and [2:0] for the weekday. A field with bit 7 = 1 is ignored.
- R3: On a clock edge where `tick` is 1, the flag becomes 1 when every enabled field equals the current time and the previous tick's evaluation was not a match.
- R4: The flag stays 1 until a control write with bit 3 = 0 clears it. A control write with bit 3 = 1 leaves the flag unchanged. If a set and a clear happen on the same edge, the set wins.
- R5: After the flag is cleared while the match persists, further matching ticks do not set it again. Only a non-matching tick followed by a matching tick sets it again.
- R6: When all four enable bits are 1, the flag is never set.
- R7: After reset, every alarm register reads 0x80, the control register reads 0, `irq_drive_low` is 0 and `rd_data` is 0.
- R8: `irq_drive_low` is 1 exactly when the flag and the interrupt enable are both 1. It changes on the same edge as they do.
- R9: Changes of the current time while `tick` is 0 neither set the flag nor count as an evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-update strobe; evaluation cycle |
| cur_min | input | 8 | Current minute, BCD |
| cur_hour | input | 8 | Current hour, BCD |
| cur_date | input | 8 | Current date, BCD |
| cur_wday | input | 8 | Current weekday |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Registered read data |
| irq_drive_low | output | 1 | Pull the open-drain interrupt pin low |

## Verification
A wrong bit in the match-history state is visible only at the next tick. It shows up as a missing flag, or as a flag that reappears while the match still holds, and can be read back through the control register two cycles later. A wrong enable or compare mask causes a flag mismatch on the first tick pattern that isolates that field. For this reason the sweep walks all sixteen enable combinations against all sixteen per-field match patterns. Interrupt gating errors appear on `irq_drive_low` on the same edge as the flag change.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int ALM_DATA_W   = 8;
  localparam int ALM_ADDR_W   = 3;
  localparam int ALM_FIELDS   = 4;
  localparam int ALM_CTRL_ADR = 0;
  localparam int ALM_FLD_BASE = 1;
  localparam int ALM_FLAG_BIT = 3;
  localparam int ALM_IE_BIT   = 1;

  // compared bits per field: minute, hour, date, weekday
  function automatic logic [ALM_DATA_W-1:0] field_mask(input int idx);
    case (idx)
      0:       return 8'h7F;
      1:       return 8'h3F;
      2:       return 8'h3F;
      default: return 8'h07;
    endcase
  endfunction
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] VAL_MASK = '1
) (
  input  logic [DATA_W-1:0] alarm_val,
  input  logic [DATA_W-1:0] cur_val,
  output logic              active,
  output logic              hit
);
  logic same;
  always_comb begin
    active = ~alarm_val[DATA_W-1];
    same   = (((alarm_val ^ cur_val) & VAL_MASK) == '0);
    hit    = active ? same : 1'b1;
  end
endmodule

// File: rtl/alarm_regfile.sv
module alarm_regfile #(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 3,
  parameter int NUM_FIELDS = 4,
  parameter int FIELD_BASE = 1
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               wr_en,
  input  logic [ADDR_W-1:0]                  wr_addr,
  input  logic [DATA_W-1:0]                  wr_data,
  output logic [NUM_FIELDS-1:0][DATA_W-1:0]  regs
);
  localparam logic [DATA_W-1:0] RESET_VAL = DATA_W'(1) << (DATA_W-1);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_FIELDS; i++) regs[i] <= RESET_VAL;
    end else begin
      for (int i = 0; i < NUM_FIELDS; i++)
        if (wr_en && wr_addr == ADDR_W'(FIELD_BASE + i)) regs[i] <= wr_data;
    end
  end

  // R1: alarm registers change only through writes
  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(regs));
endmodule

// File: rtl/alarm_flag_ctrl.sv
module alarm_flag_ctrl #(
  parameter int DATA_W   = 8,
  parameter int FLAG_BIT = 3,
  parameter int IE_BIT   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              match_now,
  input  logic              any_active,
  input  logic              ctrl_wr,
  input  logic [DATA_W-1:0] ctrl_wdata,
  output logic              flag_q,
  output logic              ie_q,
  output logic              irq_q
);
  logic match_prev_q;
  logic set_evt, clr_evt, flag_d, ie_d;

  always_comb begin
    set_evt = tick && match_now && !match_prev_q;
    clr_evt = ctrl_wr && !ctrl_wdata[FLAG_BIT];
    flag_d  = set_evt ? 1'b1 : (clr_evt ? 1'b0 : flag_q);
    ie_d    = ctrl_wr ? ctrl_wdata[IE_BIT] : ie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_prev_q <= 1'b0;
      flag_q       <= 1'b0;
      ie_q         <= 1'b0;
      irq_q        <= 1'b0;
    end else begin
      if (tick) match_prev_q <= match_now;
      flag_q <= flag_d;
      ie_q   <= ie_d;
      irq_q  <= flag_d & ie_d;
    end
  end

  p_set_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(tick));
  p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !(ctrl_wr && !ctrl_wdata[FLAG_BIT])) |=> flag_q);
  p_no_reset_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && match_prev_q && !flag_q) |=> !flag_q);
  p_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (!any_active && !flag_q) |=> !flag_q);
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (flag_q && ie_q));
  p_no_tick_r9: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(match_prev_q));
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit
  import alarm_pkg::*;
#(
  parameter int DATA_W     = ALM_DATA_W,
  parameter int ADDR_W     = ALM_ADDR_W,
  parameter int NUM_FIELDS = ALM_FIELDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [DATA_W-1:0] cur_min,
  input  logic [DATA_W-1:0] cur_hour,
  input  logic [DATA_W-1:0] cur_date,
  input  logic [DATA_W-1:0] cur_wday,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_drive_low
);
  localparam logic [ADDR_W-1:0] CTRL_ADR = ADDR_W'(ALM_CTRL_ADR);

  logic [NUM_FIELDS-1:0][DATA_W-1:0] alarm_regs;
  logic [NUM_FIELDS-1:0][DATA_W-1:0] cur_vec;
  logic [NUM_FIELDS-1:0] f_active, f_hit;
  logic any_active, match_now, ctrl_wr, flag_q, ie_q, irq_q;
  logic [DATA_W-1:0] rd_next;

  assign cur_vec = {cur_wday, cur_date, cur_hour, cur_min};

  alarm_regfile #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_FIELDS(NUM_FIELDS),
    .FIELD_BASE(ALM_FLD_BASE)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .regs(alarm_regs)
  );

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    alarm_field_cmp #(
      .DATA_W(DATA_W), .VAL_MASK(DATA_W'(field_mask(g)))
    ) u_cmp (
      .alarm_val(alarm_regs[g]), .cur_val(cur_vec[g]),
      .active(f_active[g]), .hit(f_hit[g])
    );
  end

  assign any_active = |f_active;
  assign match_now  = any_active && (&f_hit);
  assign ctrl_wr    = wr_en && (wr_addr == CTRL_ADR);

  alarm_flag_ctrl #(
    .DATA_W(DATA_W), .FLAG_BIT(ALM_FLAG_BIT), .IE_BIT(ALM_IE_BIT)
  ) u_flag (
    .clk(clk), .rst(rst), .tick(tick), .match_now(match_now),
    .any_active(any_active), .ctrl_wr(ctrl_wr), .ctrl_wdata(wr_data),
    .flag_q(flag_q), .ie_q(ie_q), .irq_q(irq_q)
  );

  always_comb begin
    rd_next = '0;
    if (rd_addr == CTRL_ADR) begin
      rd_next[ALM_FLAG_BIT] = flag_q;
      rd_next[ALM_IE_BIT]   = ie_q;
    end else begin
      for (int i = 0; i < NUM_FIELDS; i++)
        if (rd_addr == ADDR_W'(ALM_FLD_BASE + i)) rd_next = alarm_regs[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  assign irq_drive_low = irq_q;

  // R6: with no enabled field the unit reports no match
  p_no_match_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !any_active |-> !match_now);
endmodule

// File: tb/alarm_match_unit_test.sv
module alarm_match_unit_test;
  logic clk = 0, rst = 1, tick = 0, wr_en = 0;
  logic [7:0] cur_min = 0, cur_hour = 0, cur_date = 0, cur_wday = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic irq_drive_low;
  int n_checks = 0, n_err = 0;
  logic [7:0] rv;

  logic [7:0] base [4] = '{8'h25, 8'h13, 8'h07, 8'h04};
  logic [7:0] alt  [4] = '{8'h26, 8'h14, 8'h08, 8'h05};
  logic [7:0] m_reg [4];
  logic m_flag = 0, m_ie = 0, m_prev = 0;

  always #4 clk = ~clk;

  alarm_match_unit uut (
    .clk(clk), .rst(rst), .tick(tick), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_date(cur_date), .cur_wday(cur_wday), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_drive_low(irq_drive_low)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
    if (a >= 1 && a <= 4) m_reg[a-1] = d;
    if (a == 0) begin
      if (!d[3]) m_flag = 0;
      m_ie = d[1];
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  function automatic logic model_match(input logic [7:0] c [4]);
    logic [7:0] msk [4] = '{8'h7F, 8'h3F, 8'h3F, 8'h07};
    logic any = 0, all = 1;
    for (int i = 0; i < 4; i++)
      if (!m_reg[i][7]) begin
        any = 1;
        if (((m_reg[i] ^ c[i]) & msk[i]) != 0) all = 0;
      end
    return any && all;
  endfunction

  // one tick; optionally a control write on the same edge
  task automatic do_tick(input logic [7:0] c [4], input logic with_wr, input logic [7:0] wd);
    logic mm;
    @(negedge clk);
    cur_min = c[0]; cur_hour = c[1]; cur_date = c[2]; cur_wday = c[3]; tick = 1;
    if (with_wr) begin wr_en = 1; wr_addr = 0; wr_data = wd; end
    @(negedge clk); tick = 0; wr_en = 0;
    mm = model_match(c);
    if (with_wr) begin
      if (!wd[3]) m_flag = 0;
      m_ie = wd[1];
    end
    if (mm && !m_prev) m_flag = 1;
    m_prev = mm;
  endtask

  function automatic logic [7:0] ctrl_exp();
    return {4'b0, m_flag, 1'b0, m_ie, 1'b0};
  endfunction

  task automatic pattern_tick(input int p);
    logic [7:0] c [4];
    for (int i = 0; i < 4; i++) c[i] = p[i] ? base[i] : alt[i];
    do_tick(c, 0, 8'h00);
  endtask

  initial begin
    #(8 * 150000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) m_reg[i] = 8'h80;
    repeat (3) @(negedge clk);
    rst = 0;
    // R7: reset state
    chk("R7 irq", {7'b0, irq_drive_low}, 8'h00);
    chk("R7 rd_data", rd_data, 8'h00);
    for (int a = 1; a <= 4; a++) begin rd(3'(a), rv); chk("R7 alarm reg", rv, 8'h80); end
    rd(0, rv); chk("R7 ctrl", rv, 8'h00);

    // R1: readback and unused addresses
    wr(5, 8'h55); rd(5, rv); chk("R1 addr5", rv, 8'h00);
    wr(7, 8'hAA); rd(7, rv); chk("R1 addr7", rv, 8'h00);
    for (int a = 1; a <= 4; a++) begin wr(3'(a), 8'hC0 | 8'(a)); rd(3'(a), rv); chk("R1 readback", rv, 8'hC0 | 8'(a)); end
    wr(0, 8'hF7); rd(0, rv); chk("R1 ctrl bits", rv, ctrl_exp());

    // R2 R3 R5 R6 R8: every enable mask against every match pattern
    for (int mask = 0; mask < 16; mask++) begin
      for (int i = 0; i < 4; i++) wr(3'(i + 1), mask[i] ? base[i] : (base[i] | 8'h80));
      wr(0, (mask % 3 != 0) ? 8'h02 : 8'h00);
      for (int p = 0; p < 16; p++) begin
        pattern_tick(p);
        chk(mask == 0 ? "R6 irq" : "R8 irq", {7'b0, irq_drive_low}, {7'b0, m_flag & m_ie});
        rd(0, rv);
        chk(mask == 0 ? "R6 flag" : "R3 R2 flag", rv, ctrl_exp());
        if (p % 4 == 3) wr(0, {6'b0, m_ie, 1'b0});
      end
    end

    // R2: weekday compared on low three bits only
    for (int i = 0; i < 3; i++) wr(3'(i + 1), 8'h80);
    wr(4, 8'h04); wr(0, 8'h02);
    pattern_tick(0);
    begin
      logic [7:0] c [4] = '{8'h00, 8'h00, 8'h00, 8'h0C};
      do_tick(c, 0, 8'h00);
    end
    rd(0, rv); chk("R2 masked weekday", rv, 8'h0A);

    // R4: write 1 keeps, write 0 clears
    wr(0, 8'h0A); rd(0, rv); chk("R4 write1 keeps", rv, 8'h0A);
    chk("R8 irq on", {7'b0, irq_drive_low}, 8'h01);
    wr(0, 8'h08); chk("R8 irq gated", {7'b0, irq_drive_low}, 8'h00);
    rd(0, rv); chk("R4 ie off flag kept", rv, 8'h08);
    wr(0, 8'h02); rd(0, rv); chk("R4 write0 clears", rv, 8'h02);

    // R5: match persists after clear -> no re-set
    wr(4, 8'h04);
    pattern_tick(15); rd(0, rv); chk("R5 held match", rv, 8'h02);
    pattern_tick(0);  pattern_tick(15); rd(0, rv); chk("R5 re-entry", rv, 8'h0A);

    // R4: set wins over a clear on the same edge
    wr(0, 8'h02); pattern_tick(0);
    begin
      logic [7:0] c [4] = '{base[0], base[1], base[2], base[3]};
      do_tick(c, 1, 8'h02);
    end
    rd(0, rv); chk("R4 set wins", rv, ctrl_exp());
    chk("R4 set wins model", ctrl_exp(), 8'h0A);

    // R9: time changes without tick
    wr(0, 8'h02); pattern_tick(0);
    @(negedge clk); cur_min = base[0]; cur_hour = base[1]; cur_date = base[2]; cur_wday = base[3];
    repeat (5) @(negedge clk);
    rd(0, rv); chk("R9 no tick no set", rv, 8'h02);
    pattern_tick(15); rd(0, rv); chk("R9 first tick sets", rv, 8'h0A);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule